// File: doc/BRIEF.md
# Variable-Range Memory Type Resolver

This block keeps a small set of programmable address-range descriptors and returns the memory type for any physical address presented to it. Each descriptor is made of two 64-bit registers. The base register holds a memory-type code and a page-aligned base frame number. The mask register holds an enable flag and a page-aligned frame mask. An address falls inside a descriptor when the masked frame number of the address equals the masked base frame number. The mask is an arbitrary bit pattern, so a range does not have to be contiguous. Any address that no enabled descriptor claims takes a programmable default type.

Software programs the descriptors through a single-cycle register-write port. Each write selects the base register, the mask register or the default-type register. The block checks every write against the set of bits that may be written. A write that sets any reserved bit is refused, changes nothing, and raises a one-cycle fault pulse. Lookups come in on a separate port. Each lookup returns the resolved type and a hit flag exactly one cycle later. When several enabled descriptors overlap, a fixed precedence picks the result.

Top module: `mtr_resolver`

## Requirements
- R1: After reset every descriptor is disabled, the default type is 0 (uncacheable), `wr_fault` and `res_valid` are low, and a lookup returns type 0 with `res_hit` low.
- R2: A base write (`wr_kind`=0) stores the type from data bits 7:0 and the base frame from bits PA_W-1:12. A base write that sets any of bits 11:8 or bits 63:PA_W is refused and leaves the descriptor unchanged.
- R3: A mask write (`wr_kind`=1) stores the enable flag from data bit 11 and the frame mask from bits PA_W-1:12. A mask write that sets any of bits 10:0 or bits 63:PA_W is refused and leaves the descriptor unchanged.
- R4: A default write (`wr_kind`=2) stores the default type from data bits 7:0. If it sets any of bits 63:8 it is refused and the stored default is unchanged.
- R5: An enabled descriptor matches an address when (addr[PA_W-1:12] & mask) == (base & mask). This holds for non-contiguous masks.
- R6: A descriptor whose enable flag is clear never matches, whatever its base and mask hold.
- R7: When no enabled descriptor matches, the result carries the default type and `res_hit` is low.
- R8: If any matching descriptor has type 0 (uncacheable), the result is type 0.
- R9: If there is no uncacheable match, the result is resolved as follows. When all matching types are equal, that type is returned. When the matching types are only 4 (write-through) and 6 (write-back), type 4 is returned. Any other mix returns type 0. `res_hit` is high for every match case.
- R10: `res_valid` is high exactly one cycle after a cycle in which `lk_valid` was high, and low otherwise. The result reflects the register contents present in the cycle of the lookup.
- R11: `wr_fault` pulses high for one cycle, the cycle after a refused write. A refused write is one that sets a reserved bit, uses `wr_kind`=3, or selects a descriptor index that does not exist. `wr_fault` is never high after an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Target register: 0 base, 1 mask, 2 default, 3 invalid |
| wr_idx | input | IDX_W | Descriptor index for base/mask writes |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | One-cycle pulse after a refused write |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | PA_W | Physical address to resolve |
| res_valid | output | 1 | Result strobe, one cycle after `lk_valid` |
| res_hit | output | 1 | At least one enabled descriptor matched |
| res_type | output | 8 | Resolved memory type |

## Verification
The assertions take for granted that `lk_valid` and `wr_en` are driven to known values on every clock after reset. They also assume that the stored default type and the enable flags seen by a lookup are the values that were present in the lookup cycle itself. The stimulus respects this. It changes inputs only on the falling clock edge and holds each strobe for exactly one cycle. Random descriptor contents use type codes drawn only from the defined set (0, 1, 4, 5, 6). Random refused writes set exactly one reserved bit, so each refusal can be attributed to a known cause.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    localparam int REG_W   = 64;
    localparam int PFN_LSB = 12;
    localparam int TYPE_W  = 8;
    localparam int EN_BIT  = 11;

    typedef logic [TYPE_W-1:0] mtype_t;

    localparam mtype_t MT_UC = 8'd0;
    localparam mtype_t MT_WC = 8'd1;
    localparam mtype_t MT_WT = 8'd4;
    localparam mtype_t MT_WP = 8'd5;
    localparam mtype_t MT_WB = 8'd6;

    typedef enum logic [1:0] {
        WK_BASE = 2'd0,
        WK_MASK = 2'd1,
        WK_DFLT = 2'd2,
        WK_NONE = 2'd3
    } wkind_e;

    typedef struct packed {
        logic   hit;
        mtype_t mt;
    } res_t;

    // Bits that software may set for a given register kind.
    function automatic logic [REG_W-1:0] writable_bits(wkind_e kind, int pa_w);
        logic [REG_W-1:0] w;
        w = '0;
        for (int i = 0; i < REG_W; i++) begin
            case (kind)
                WK_BASE: w[i] = (i < TYPE_W) || (i >= PFN_LSB && i < pa_w);
                WK_MASK: w[i] = (i == EN_BIT) || (i >= PFN_LSB && i < pa_w);
                WK_DFLT: w[i] = (i < TYPE_W);
                default: w[i] = 1'b0;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/mtr_regs.sv
module mtr_regs
    import mtr_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int PA_W      = 36,
    localparam int PFN_W    = PA_W - PFN_LSB,
    localparam int IDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  wkind_e                            wr_kind,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [REG_W-1:0]                  wr_data,
    output logic [NUM_PAIRS-1:0]              en_o,
    output logic [NUM_PAIRS-1:0][PFN_W-1:0]   base_o,
    output logic [NUM_PAIRS-1:0][PFN_W-1:0]   mask_o,
    output logic [NUM_PAIRS-1:0][TYPE_W-1:0]  type_o,
    output mtype_t                            dflt_o,
    output logic                              fault_o
);

    logic [REG_W-1:0] allowed;
    logic             idx_ok;
    logic             reject;
    logic             accept;

    always_comb begin
        allowed = writable_bits(wr_kind, PA_W);
        idx_ok  = (int'(wr_idx) < NUM_PAIRS) || (wr_kind == WK_DFLT);
        reject  = wr_en && (((wr_data & ~allowed) != '0) ||
                            (wr_kind == WK_NONE) || !idx_ok);
        accept  = wr_en && !reject;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_o <= 1'b0;
            dflt_o  <= MT_UC;
        end else begin
            fault_o <= reject;
            if (accept && wr_kind == WK_DFLT)
                dflt_o <= wr_data[TYPE_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic sel;
        assign sel = accept && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                en_o[g]   <= 1'b0;
                base_o[g] <= '0;
                mask_o[g] <= '0;
                type_o[g] <= MT_UC;
            end else if (sel) begin
                if (wr_kind == WK_BASE) begin
                    base_o[g] <= wr_data[PA_W-1:PFN_LSB];
                    type_o[g] <= wr_data[TYPE_W-1:0];
                end else if (wr_kind == WK_MASK) begin
                    mask_o[g] <= wr_data[PA_W-1:PFN_LSB];
                    en_o[g]   <= wr_data[EN_BIT];
                end
            end
        end
    end

endmodule

// File: rtl/mtr_match.sv
module mtr_match
    import mtr_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int PA_W      = 36,
    localparam int PFN_W    = PA_W - PFN_LSB
) (
    input  logic [PA_W-1:0]                  addr,
    input  logic [NUM_PAIRS-1:0]             en,
    input  logic [NUM_PAIRS-1:0][PFN_W-1:0]  base,
    input  logic [NUM_PAIRS-1:0][PFN_W-1:0]  mask,
    output logic [NUM_PAIRS-1:0]             hit
);

    logic [PFN_W-1:0] pfn;
    assign pfn = addr[PA_W-1:PFN_LSB];

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_cmp
        assign hit[g] = en[g] && (((pfn ^ base[g]) & mask[g]) == '0);
    end

endmodule

// File: rtl/mtr_prio.sv
module mtr_prio
    import mtr_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  logic [NUM_PAIRS-1:0]              hit,
    input  logic [NUM_PAIRS-1:0][TYPE_W-1:0]  types,
    input  mtype_t                            dflt,
    output res_t                              res
);

    logic   any_m, uc_m, wt_m, wb_m, oth_m, mixed;
    mtype_t first;

    always_comb begin
        any_m = 1'b0;
        uc_m  = 1'b0;
        wt_m  = 1'b0;
        wb_m  = 1'b0;
        oth_m = 1'b0;
        mixed = 1'b0;
        first = MT_UC;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (hit[i]) begin
                if (!any_m)
                    first = types[i];
                else if (types[i] != first)
                    mixed = 1'b1;
                any_m = 1'b1;
                uc_m  = uc_m | (types[i] == MT_UC);
                wt_m  = wt_m | (types[i] == MT_WT);
                wb_m  = wb_m | (types[i] == MT_WB);
                oth_m = oth_m | !((types[i] == MT_WT) || (types[i] == MT_WB));
            end
        end

        res.hit = any_m;
        if (!any_m)
            res.mt = dflt;
        else if (uc_m)
            res.mt = MT_UC;
        else if (!mixed)
            res.mt = first;
        else if (wt_m && wb_m && !oth_m)
            res.mt = MT_WT;
        else
            res.mt = MT_UC;
    end

endmodule

// File: rtl/mtr_resolver.sv
module mtr_resolver
    import mtr_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int PA_W      = 36,
    localparam int PFN_W    = PA_W - PFN_LSB,
    localparam int IDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [63:0]       wr_data,
    output logic              wr_fault,
    input  logic              lk_valid,
    input  logic [PA_W-1:0]   lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [7:0]        res_type
);

    logic [NUM_PAIRS-1:0]              en_vec;
    logic [NUM_PAIRS-1:0][PFN_W-1:0]   base_vec;
    logic [NUM_PAIRS-1:0][PFN_W-1:0]   mask_vec;
    logic [NUM_PAIRS-1:0][TYPE_W-1:0]  type_vec;
    mtype_t                            dflt_type;
    logic [NUM_PAIRS-1:0]              hit_vec;
    res_t                              res_c;
    res_t                              res_q;
    logic                              vld_q;

    mtr_regs #(.NUM_PAIRS(NUM_PAIRS), .PA_W(PA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_kind (wkind_e'(wr_kind)),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .en_o    (en_vec),
        .base_o  (base_vec),
        .mask_o  (mask_vec),
        .type_o  (type_vec),
        .dflt_o  (dflt_type),
        .fault_o (wr_fault)
    );

    mtr_match #(.NUM_PAIRS(NUM_PAIRS), .PA_W(PA_W)) u_match (
        .addr (lk_addr),
        .en   (en_vec),
        .base (base_vec),
        .mask (mask_vec),
        .hit  (hit_vec)
    );

    mtr_prio #(.NUM_PAIRS(NUM_PAIRS)) u_prio (
        .hit   (hit_vec),
        .types (type_vec),
        .dflt  (dflt_type),
        .res   (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= lk_valid;
            if (lk_valid)
                res_q <= res_c;
        end
    end

    assign res_valid = vld_q;
    assign res_hit   = res_q.hit;
    assign res_type  = res_q.mt;

endmodule

// File: rtl/mtr_resolver_chk.sv
module mtr_resolver_chk #(
    parameter int NUM_PAIRS = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic                  lk_valid,
    input logic                  res_valid,
    input logic                  res_hit,
    input logic [7:0]            res_type,
    input logic                  wr_fault,
    input logic [7:0]            dflt,
    input logic [NUM_PAIRS-1:0]  en_vec
);

    assert_lat_R10: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);

    assert_fault_src_R11: assert property (@(posedge clk) disable iff (rst)
        wr_fault |-> $past(wr_en));

    assert_miss_dflt_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_type == $past(dflt)));

    assert_off_nohit_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && ($past(en_vec) == '0)) |-> !res_hit);

    assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && !wr_fault));

endmodule

bind mtr_resolver mtr_resolver_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .lk_valid  (lk_valid),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_type  (res_type),
    .wr_fault  (wr_fault),
    .dflt      (dflt_type),
    .en_vec    (en_vec)
);

// File: tb/tb_mtr_resolver.sv
module tb_mtr_resolver;

    localparam int NP   = 4;
    localparam int PA_W = 36;
    localparam int FW   = PA_W - 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_kind = 2'd0;
    logic [1:0]        wr_idx = 2'd0;
    logic [63:0]       wr_data = '0;
    logic              wr_fault;
    logic              lk_valid = 1'b0;
    logic [PA_W-1:0]   lk_addr = '0;
    logic              res_valid;
    logic              res_hit;
    logic [7:0]        res_type;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state kept by the bench.
    bit          m_en   [NP];
    logic [FW-1:0] m_base [NP];
    logic [FW-1:0] m_mask [NP];
    logic [7:0]  m_type [NP];
    logic [7:0]  m_dflt;

    logic [7:0] type_set [5] = '{8'd0, 8'd1, 8'd4, 8'd5, 8'd6};

    always #10 clk = ~clk;

    mtr_resolver #(.NUM_PAIRS(NP), .PA_W(PA_W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_fault(wr_fault),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
        .res_hit(res_hit), .res_type(res_type)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] expect_res(input logic [PA_W-1:0] a);
        logic [FW-1:0] pfn;
        bit any, uc, wt, wb, oth, mixed;
        logic [7:0] first;
        pfn = a[PA_W-1:12];
        any = 0; uc = 0; wt = 0; wb = 0; oth = 0; mixed = 0; first = 8'd0;
        for (int i = 0; i < NP; i++) begin
            if (m_en[i] && ((pfn & m_mask[i]) == (m_base[i] & m_mask[i]))) begin
                if (!any) first = m_type[i];
                else if (m_type[i] != first) mixed = 1;
                any = 1;
                if (m_type[i] == 8'd0) uc = 1;
                if (m_type[i] == 8'd4) wt = 1;
                else if (m_type[i] == 8'd6) wb = 1;
                else oth = 1;
            end
        end
        if (!any) return {1'b0, m_dflt};
        if (uc) return {1'b1, 8'd0};
        if (!mixed) return {1'b1, first};
        if (wt && wb && !oth) return {1'b1, 8'd4};
        return {1'b1, 8'd0};
    endfunction

    function automatic logic [63:0] base_word(input logic [FW-1:0] b, input logic [7:0] t);
        return (64'(b) << 12) | 64'(t);
    endfunction

    function automatic logic [63:0] mask_word(input logic [FW-1:0] m, input bit v);
        return (64'(m) << 12) | (64'(v) << 11);
    endfunction

    task automatic do_write(input logic [1:0] kind, input int idx,
                            input logic [63:0] data, input bit exp_fault,
                            input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = kind; wr_idx = 2'(idx); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        chk(wr_fault == exp_fault, req, 64'(wr_fault), 64'(exp_fault));
        if (!exp_fault) begin
            case (kind)
                2'd0: begin m_base[idx] = data[PA_W-1:12]; m_type[idx] = data[7:0]; end
                2'd1: begin m_mask[idx] = data[PA_W-1:12]; m_en[idx] = data[11]; end
                2'd2: m_dflt = data[7:0];
                default: ;
            endcase
        end
    endtask

    task automatic do_look(input logic [PA_W-1:0] a, input string req);
        logic [8:0] e;
        e = expect_res(a);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(res_valid === 1'b1, req, 64'(res_valid), 64'd1);
        chk({res_hit, res_type} === e, req, 64'({res_hit, res_type}), 64'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NP; i++) begin
            m_en[i] = 0; m_base[i] = '0; m_mask[i] = '0; m_type[i] = 8'd0;
        end
        m_dflt = 8'd0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(res_valid == 1'b0, "R1", 64'(res_valid), 64'd0);
        chk(wr_fault == 1'b0, "R1", 64'(wr_fault), 64'd0);
        do_look(36'h1_2345_6000, "R1");

        // R10 no lookup -> no result
        @(negedge clk);
        chk(res_valid == 1'b0, "R10", 64'(res_valid), 64'd0);

        // R4 default type write and reserved rejection
        do_write(2'd2, 0, 64'h6, 0, "R4");
        do_look(36'h0_0000_1000, "R7");
        do_write(2'd2, 0, 64'h105, 1, "R4");
        @(negedge clk);
        chk(wr_fault == 1'b0, "R11", 64'(wr_fault), 64'd0);
        do_look(36'h0_0000_1000, "R4");

        // R6 base written, enable still clear
        do_write(2'd0, 0, base_word(24'h100000, 8'd6), 0, "R2");
        do_write(2'd1, 0, mask_word(24'hFFF000, 1'b0), 0, "R3");
        do_look(36'h1_0000_0000, "R6");

        // R5 contiguous range
        do_write(2'd1, 0, mask_word(24'hFFF000, 1'b1), 0, "R3");
        do_look(36'h1_0008_1000, "R5");
        do_look(36'h2_0000_0000, "R7");

        // R2 / R3 reserved bits rejected, contents unchanged
        do_write(2'd0, 0, base_word(24'h200000, 8'd4) | 64'h200, 1, "R2");
        do_write(2'd0, 0, base_word(24'h200000, 8'd4) | (64'h1 << 50), 1, "R2");
        do_write(2'd1, 0, mask_word(24'h000000, 1'b1) | (64'h1 << 40), 1, "R3");
        do_write(2'd1, 0, mask_word(24'h000000, 1'b1) | 64'h20, 1, "R3");
        do_look(36'h1_0000_0000, "R2");
        do_look(36'h3_0000_0000, "R3");

        // R11 invalid kind
        do_write(2'd3, 0, 64'h0, 1, "R11");

        // R5 non-contiguous mask
        do_write(2'd0, 1, base_word(24'h050000, 8'd1), 0, "R5");
        do_write(2'd1, 1, mask_word(24'h0F0F00, 1'b1), 0, "R5");
        do_look(36'h0_5A0A_0000, "R5");
        do_look(36'h0_5A1A_0000, "R5");

        // R9 WT + WB -> WT
        do_write(2'd0, 2, base_word(24'h100000, 8'd4), 0, "R9");
        do_write(2'd1, 2, mask_word(24'hFF0000, 1'b1), 0, "R9");
        do_look(36'h1_0000_0000, "R9");
        // R9 identical types
        do_write(2'd0, 2, base_word(24'h100000, 8'd6), 0, "R9");
        do_look(36'h1_0000_0000, "R9");
        // R9 other mix -> UC
        do_write(2'd0, 2, base_word(24'h100000, 8'd1), 0, "R9");
        do_look(36'h1_0000_0000, "R9");
        // R8 UC wins
        do_write(2'd0, 3, base_word(24'h100000, 8'd0), 0, "R8");
        do_write(2'd1, 3, mask_word(24'h800000, 1'b1), 0, "R8");
        do_look(36'h1_0000_0000, "R8");

        // Random phase
        for (int r = 0; r < 10; r++) begin
            for (int w = 0; w < 6; w++) begin
                int idx;
                int pick;
                idx = $urandom_range(0, NP - 1);
                pick = $urandom_range(0, 9);
                if (pick < 4)
                    do_write(2'd0, idx, base_word(FW'($urandom),
                             type_set[$urandom_range(0, 4)]), 0, "R2");
                else if (pick < 8)
                    do_write(2'd1, idx, mask_word({8'($urandom), 16'h0},
                             1'($urandom)), 0, "R3");
                else begin
                    int rb;
                    rb = $urandom_range(0, 31);
                    if (pick == 8)
                        do_write(2'd0, idx, (64'h1 << ((rb < 4) ? 8 + rb : 32 + rb)), 1, "R2");
                    else
                        do_write(2'd1, idx, (64'h1 << ((rb < 11) ? rb : 36 + (rb % 28))), 1, "R3");
                end
            end
            for (int k = 0; k < 20; k++) begin
                logic [FW-1:0] pf;
                int j;
                j = $urandom_range(0, NP - 1);
                if ($urandom_range(0, 1) == 1)
                    pf = m_base[j] ^ FW'($urandom_range(0, 16'hFFFF));
                else
                    pf = FW'($urandom);
                do_look({pf, 12'($urandom)}, "R5");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule